// File: doc/BRIEF.md
# Bus Error Capture Unit

This block records error events reported by a neighbouring bus interface. The error detector sends a single-cycle strobe that carries a vector of error-type bits, plus the address, data and parity seen on the bus when the error occurred. Each error type has a bit in a mask register that decides whether it is reported. The type bits that pass the mask are accumulated in a cause register. The address, data and parity are stored only for the first reported error after the cause register was last empty. That snapshot then stays fixed while more errors pile up, so software always reads the context of the fault that opened the episode.

Software accesses the unit through a small register port. Reads are combinational and writes take effect on a single-cycle strobe. A handler reads the cause register and then writes back the bitwise inverse of what it read. Bits written as zero are cleared, so this clears exactly the bits the handler saw and keeps any that arrived in the meantime. The interrupt output is a level signal. It stays high while any cause bit is also enabled in the mask. Bit 0 of the mask register and of a separate system-error mask register is reserved and always reads as zero.

Top module: `bus_err_capture`

## Requirements
- R1: On a cycle with `err_valid` high, each bit of `err_type` that is also set in the mask register is ORed into the cause register. Type bits whose mask bit is 0 leave the cause register unchanged.
- R2: When a reported error arrives and the cause register is all zeros (after any same-cycle write), the unit stores the error's address, data and parity. These values appear in the capture registers from the next cycle.
- R3: While the cause register holds any set bit, the capture registers keep their values. Later errors do not change them, and clearing the cause register does not erase them.
- R4: A write to the cause register clears every cause bit where the written data is 0 and keeps every bit where it is 1.
- R5: The mask register reads back the last value written, with bit 0 forced to 0. For example, writing 0xFFFFFFFF reads back 0xFFFFFFFE, and writing 0x00A50C24 reads back 0x00A50C24.
- R6: The system-error mask register reads back the last value written, with bit 0 forced to 0.
- R7: `irq` is high exactly when the cause register ANDed with the mask register is non-zero. Changing the mask alone can therefore raise or drop `irq`.
- R8: After reset, every register reads 0 and `irq` is low.
- R9: If a cause write and a reported error fall in the same cycle, the new error bits are set after the write's clearing is applied. If that clearing empties the cause register, the new error is captured.
- R10: The register offsets on `reg_addr` are: 0 cause, 1 mask, 2 system-error mask, 3 parity (zero-extended), 4 address bits 31:0, 5 address bits 63:32, 6 data bits 31:0, 7 data bits 63:32. Offsets 3 to 7 are read-only, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_valid | input | 1 | Single-cycle error strobe |
| err_type | input | 32 | Error-type bits that come with the strobe |
| err_addr | input | 64 | Bus address at the error |
| err_data | input | 64 | Bus data at the error |
| err_parity | input | 8 | Bus parity at the error |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that `err_valid` and `reg_wr` are sampled once per clock. They also assume that the error fields are valid in the same cycle as the strobe, and that reset is held for at least one edge before anything is driven. The bench drives every input on the falling edge and holds each strobe for exactly one cycle. It lowers reset only after the inputs are idle. It stacks a cause write and an error in the same cycle only in the scenario written for that purpose.

// File: rtl/bec_pkg.sv
package bec_pkg;

  localparam int REG_W     = 32;
  localparam int CAP_WORDS = 2;
  localparam int CAP_W     = REG_W * CAP_WORDS;
  localparam int RADDR_W   = 3;

  typedef enum logic [RADDR_W-1:0] {
    RG_CAUSE   = 3'd0,
    RG_MASK    = 3'd1,
    RG_SYSMASK = 3'd2,
    RG_PARITY  = 3'd3,
    RG_ADDR_LO = 3'd4,
    RG_ADDR_HI = 3'd5,
    RG_DATA_LO = 3'd6,
    RG_DATA_HI = 3'd7
  } bec_reg_e;

  // write-zero clear: a 1 in the write data keeps the bit
  function automatic logic [REG_W-1:0] f_w0_clear(input logic [REG_W-1:0] cur,
                                                  input logic [REG_W-1:0] wd);
    return cur & wd;
  endfunction

  // mask write with reserved bits held at zero
  function automatic logic [REG_W-1:0] f_mask_store(input logic [REG_W-1:0] wd,
                                                    input logic [REG_W-1:0] rsv);
    return wd & ~rsv;
  endfunction

  // a capture is opened only when nothing is pending
  function automatic logic f_opens_episode(input logic [REG_W-1:0] kept,
                                           input logic [REG_W-1:0] incoming);
    return (kept == '0) && (incoming != '0);
  endfunction

endpackage

// File: rtl/bec_cause.sv
module bec_cause
  import bec_pkg::*;
#(
  parameter logic [REG_W-1:0] RSV_BITS = 32'h0000_0001
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err_valid,
  input  logic [REG_W-1:0] err_type,
  input  logic             wr_cause,
  input  logic             wr_mask,
  input  logic             wr_sysmask,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] cause_q,
  output logic [REG_W-1:0] mask_q,
  output logic [REG_W-1:0] sysmask_q,
  output logic             err_hit,
  output logic             first_hit,
  output logic             irq
);

  logic [REG_W-1:0] incoming;
  logic [REG_W-1:0] cause_kept;
  logic [REG_W-1:0] cause_d;

  always_comb begin
    incoming   = err_valid ? (err_type & mask_q) : '0;
    cause_kept = wr_cause ? f_w0_clear(cause_q, wdata) : cause_q;
    cause_d    = cause_kept | incoming;
    err_hit    = (incoming != '0);
    first_hit  = f_opens_episode(cause_kept, incoming);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q   <= '0;
      mask_q    <= '0;
      sysmask_q <= '0;
    end else begin
      cause_q <= cause_d;
      if (wr_mask)    mask_q    <= f_mask_store(wdata, RSV_BITS);
      if (wr_sysmask) sysmask_q <= f_mask_store(wdata, RSV_BITS);
    end
  end

  assign irq = |(cause_q & mask_q);

  AST_CAUSE_FROM_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
    ((cause_q & ~$past(cause_q)) != '0) |-> $past(err_valid)); // R1

  AST_CAUSE_W0_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cause && !err_valid) |=> (cause_q == ($past(cause_q) & $past(wdata)))); // R4

  AST_MASK_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> (mask_q == ($past(wdata) & ~RSV_BITS))); // R5

  AST_SYSMASK_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sysmask |=> ((sysmask_q & RSV_BITS) == '0)); // R6

  AST_IRQ_HAS_REASON: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(err_hit || wr_mask)); // R7

endmodule

// File: rtl/bec_capture.sv
module bec_capture
  import bec_pkg::*;
#(
  parameter int PAR_W = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            load,
  input  logic [CAP_W-1:0]                err_addr,
  input  logic [CAP_W-1:0]                err_data,
  input  logic [PAR_W-1:0]                err_parity,
  output logic [CAP_WORDS-1:0][REG_W-1:0] addr_q,
  output logic [CAP_WORDS-1:0][REG_W-1:0] data_q,
  output logic [PAR_W-1:0]                par_q
);

  for (genvar w = 0; w < CAP_WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        addr_q[w] <= '0;
        data_q[w] <= '0;
      end else if (load) begin
        addr_q[w] <= err_addr[w*REG_W +: REG_W];
        data_q[w] <= err_data[w*REG_W +: REG_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    par_q <= '0;
    else if (load) par_q <= err_parity;
  end

endmodule

// File: rtl/bec_regmux.sv
module bec_regmux
  import bec_pkg::*;
#(
  parameter int PAR_W = 8
) (
  input  logic [RADDR_W-1:0]              reg_addr,
  input  logic [REG_W-1:0]                cause_q,
  input  logic [REG_W-1:0]                mask_q,
  input  logic [REG_W-1:0]                sysmask_q,
  input  logic [CAP_WORDS-1:0][REG_W-1:0] addr_q,
  input  logic [CAP_WORDS-1:0][REG_W-1:0] data_q,
  input  logic [PAR_W-1:0]                par_q,
  output logic [REG_W-1:0]                rdata
);

  always_comb begin
    unique case (bec_reg_e'(reg_addr))
      RG_CAUSE:   rdata = cause_q;
      RG_MASK:    rdata = mask_q;
      RG_SYSMASK: rdata = sysmask_q;
      RG_PARITY:  rdata = REG_W'(par_q);
      RG_ADDR_LO: rdata = addr_q[0];
      RG_ADDR_HI: rdata = addr_q[1];
      RG_DATA_LO: rdata = data_q[0];
      RG_DATA_HI: rdata = data_q[1];
      default:    rdata = '0;
    endcase
  end

endmodule

// File: rtl/bus_err_capture.sv
module bus_err_capture
  import bec_pkg::*;
#(
  parameter int               PAR_W    = 8,
  parameter logic [REG_W-1:0] RSV_BITS = 32'h0000_0001
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               err_valid,
  input  logic [REG_W-1:0]   err_type,
  input  logic [CAP_W-1:0]   err_addr,
  input  logic [CAP_W-1:0]   err_data,
  input  logic [PAR_W-1:0]   err_parity,
  input  logic               reg_wr,
  input  logic [RADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  output logic               irq
);

  logic                            wr_cause, wr_mask, wr_sysmask;
  logic [REG_W-1:0]                cause_q, mask_q, sysmask_q;
  logic                            err_hit, first_hit;
  logic [CAP_WORDS-1:0][REG_W-1:0] cap_addr, cap_data;
  logic [PAR_W-1:0]                cap_par;

  always_comb begin
    wr_cause   = reg_wr && (bec_reg_e'(reg_addr) == RG_CAUSE);
    wr_mask    = reg_wr && (bec_reg_e'(reg_addr) == RG_MASK);
    wr_sysmask = reg_wr && (bec_reg_e'(reg_addr) == RG_SYSMASK);
  end

  bec_cause #(.RSV_BITS(RSV_BITS)) u_cause (
    .clk        (clk),
    .rst_n      (rst_n),
    .err_valid  (err_valid),
    .err_type   (err_type),
    .wr_cause   (wr_cause),
    .wr_mask    (wr_mask),
    .wr_sysmask (wr_sysmask),
    .wdata      (reg_wdata),
    .cause_q    (cause_q),
    .mask_q     (mask_q),
    .sysmask_q  (sysmask_q),
    .err_hit    (err_hit),
    .first_hit  (first_hit),
    .irq        (irq)
  );

  bec_capture #(.PAR_W(PAR_W)) u_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (first_hit),
    .err_addr   (err_addr),
    .err_data   (err_data),
    .err_parity (err_parity),
    .addr_q     (cap_addr),
    .data_q     (cap_data),
    .par_q      (cap_par)
  );

  bec_regmux #(.PAR_W(PAR_W)) u_regmux (
    .reg_addr  (reg_addr),
    .cause_q   (cause_q),
    .mask_q    (mask_q),
    .sysmask_q (sysmask_q),
    .addr_q    (cap_addr),
    .data_q    (cap_data),
    .par_q     (cap_par),
    .rdata     (reg_rdata)
  );

  AST_CAPTURE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    ((cause_q != '0) && !wr_cause) |=>
      ($stable(cap_addr) && $stable(cap_data) && $stable(cap_par))); // R3

  AST_FIRST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    first_hit |=> ((cap_addr == $past(err_addr)) && (cap_data == $past(err_data))
                   && (cap_par == $past(err_parity)))); // R2

  AST_FIRST_NEEDS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    first_hit |-> (err_valid && ((err_type & mask_q) != '0))); // R9

endmodule

// File: tb/bus_err_capture_tb.sv
module bus_err_capture_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        err_valid = 1'b0;
  logic [31:0] err_type = '0;
  logic [63:0] err_addr = '0;
  logic [63:0] err_data = '0;
  logic [7:0]  err_parity = '0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int failures = 0;
  logic [63:0] exp_addr, exp_data;
  logic [7:0]  exp_par;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_err_capture u_dut (
    .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_type(err_type),
    .err_addr(err_addr), .err_data(err_data), .err_parity(err_parity),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic check_reg(input string req, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic check_irq(input string req, input logic exp);
    #1 check(req, {31'd0, irq}, {31'd0, exp});
  endtask

  task automatic raise(input logic [31:0] t, input logic [63:0] a, input logic [63:0] d,
                       input logic [7:0] p);
    @(negedge clk);
    err_valid = 1'b1; err_type = t; err_addr = a; err_data = d; err_parity = p;
    @(negedge clk);
    err_valid = 1'b0; err_type = '0; err_addr = '0; err_data = '0; err_parity = '0;
  endtask

  task automatic check_capture(input string req);
    check_reg({req, " addr lo"}, 3'd4, exp_addr[31:0]);
    check_reg({req, " addr hi"}, 3'd5, exp_addr[63:32]);
    check_reg({req, " data lo"}, 3'd6, exp_data[31:0]);
    check_reg({req, " data hi"}, 3'd7, exp_data[63:32]);
    check_reg({req, " parity"},  3'd3, {24'd0, exp_par});
  endtask

  task automatic t_reset;
    for (int i = 0; i < 8; i++) check_reg("R8 reset reg", 3'(i), 32'h0);
    check_irq("R8 reset irq", 1'b0);
  endtask

  task automatic t_masks;
    wr(3'd1, 32'hFFFF_FFFF);
    check_reg("R5 mask bit0 reserved", 3'd1, 32'hFFFF_FFFE);
    wr(3'd2, 32'hFFFF_FFFF);
    check_reg("R6 sysmask bit0 reserved", 3'd2, 32'hFFFF_FFFE);
    wr(3'd1, 32'h00A5_0C24);
    check_reg("R5 mask readback", 3'd1, 32'h00A5_0C24);
    check_irq("R7 no cause no irq", 1'b0);
  endtask

  task automatic t_masked_error;
    raise(32'h0000_0002, 64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 8'hFF);
    check_reg("R1 masked type ignored", 3'd0, 32'h0);
    check_irq("R1 masked type no irq", 1'b0);
    check_reg("R2 masked type no capture", 3'd4, 32'h0);
  endtask

  task automatic t_first_error;
    exp_addr = 64'h1122_3344_5566_7788;
    exp_data = 64'hCAFE_F00D_DEAD_BEEF;
    exp_par  = 8'h5A;
    raise(32'h0000_0004, exp_addr, exp_data, exp_par);
    check_reg("R1 first cause", 3'd0, 32'h0000_0004);
    check_irq("R7 irq on cause", 1'b1);
    check_capture("R2 first capture");
  endtask

  task automatic t_frozen;
    raise(32'h0000_0021, 64'h9999_0000_9999_0000, 64'h0123_4567_89AB_CDEF, 8'h11);
    check_reg("R1 accumulate unmasked only", 3'd0, 32'h0000_0024);
    check_capture("R3 frozen on second error");
  endtask

  task automatic t_irq_mask;
    wr(3'd1, 32'h0);
    check_irq("R7 mask cleared drops irq", 1'b0);
    check_reg("R7 cause kept", 3'd0, 32'h0000_0024);
    wr(3'd1, 32'h00A5_0C24);
    check_irq("R7 mask restored raises irq", 1'b1);
  endtask

  task automatic t_clear;
    wr(3'd0, ~32'h0000_0004);
    check_reg("R4 partial clear", 3'd0, 32'h0000_0020);
    check_irq("R7 irq with remaining bit", 1'b1);
    wr(3'd0, ~32'h0000_0020);
    check_reg("R4 full clear", 3'd0, 32'h0);
    check_irq("R7 irq low after clear", 1'b0);
    check_capture("R3 capture survives clear");
  endtask

  task automatic t_readonly;
    wr(3'd4, 32'h0);
    wr(3'd3, 32'h0);
    check_capture("R10 capture regs read-only");
  endtask

  task automatic t_recapture;
    exp_addr = 64'h0000_0001_F000_0000;
    exp_data = 64'h1111_2222_3333_4444;
    exp_par  = 8'hA3;
    raise(32'h0000_0800, exp_addr, exp_data, exp_par);
    check_reg("R1 new episode cause", 3'd0, 32'h0000_0800);
    check_capture("R2 recapture after clear");
  endtask

  task automatic t_same_cycle;
    exp_addr = 64'hFEDC_BA98_7654_3210;
    exp_data = 64'h0F0F_0F0F_F0F0_F0F0;
    exp_par  = 8'h3C;
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h0;
    err_valid = 1'b1; err_type = 32'h0001_0000;
    err_addr = exp_addr; err_data = exp_data; err_parity = exp_par;
    @(negedge clk);
    reg_wr = 1'b0; err_valid = 1'b0; err_type = '0;
    err_addr = '0; err_data = '0; err_parity = '0;
    check_reg("R9 error wins over clear", 3'd0, 32'h0001_0000);
    check_capture("R9 capture in clearing cycle");
    check_irq("R9 irq after same cycle", 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_masks();
    t_masked_error();
    t_first_error();
    t_frozen();
    t_irq_mask();
    t_clear();
    t_readonly();
    t_recapture();
    t_same_cycle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule